// File: doc/BRIEF.md
# PHY Register Access Port

This block gives a host CPU indirect access to a small bank of 8-bit PHY delay registers through one 32-bit command/status word in the host register window. Software first loads a PHY register index and an 8-bit write value into the word. It then sets either a write strobe or a read strobe. A handshake state machine issues one request to the PHY register bank and waits for the bank's response. It then raises an acknowledge status bit. The bit stays high until software clears the strobe, which makes a four-phase handshake. For a read, the fetched byte is returned in a separate read-data field of the same word.

The state machine has three named states. ST_IDLE waits for exactly one strobe. ST_ISSUE holds the request to the bank until the bank answers. ST_DONE shows the acknowledge and waits for both strobes to be clear.

The transitions are:
- ST_IDLE to ST_ISSUE when exactly one strobe is set.
- ST_IDLE to ST_IDLE when no strobe is set, or when both are set. A word with both strobes set is refused.
- ST_ISSUE to ST_DONE on the bank's response.
- ST_DONE to ST_IDLE once both strobes read zero.

The delay bank holds one entry per bus speed mode and comes out of reset with its initial delay settings.

Top module: `phy_acc_port`

## Requirements
- R1: After reset the command word at the access offset (default 0x10) reads all zero.
- R2: Word layout: the index is bits 7:0, the write value is bits 15:8, the read value is bits 23:16, the write strobe is bit 24, the read strobe is bit 25 and the acknowledge is bit 26. Bits 15:8 and 7:0 read back as written. A word written with both strobes clear starts no access, so the acknowledge stays 0.
- R3: After reset, bank entries 0 and 1 hold 4, entry 6 holds 9, entry 7 holds 2, entry 8 holds 3, and every other entry holds 0.
- R4: Setting only the write strobe stores bits 15:8 into the entry named by bits 7:0. The acknowledge (bit 26) rises within 10 cycles.
- R5: Setting only the read strobe returns the addressed entry in bits 23:16. The value is valid by the time the acknowledge reads 1.
- R6: The acknowledge stays 1 while a strobe remains set. It reads 0 from the second rising edge after the host write that clears both strobes.
- R7: A word with both strobes set is ignored. The acknowledge stays 0 and no bank entry changes.
- R8: Host writes to any other offset leave the command word unchanged. Host reads of any other offset return zero.
- R9: An index at or above the bank depth (default 16) is still acknowledged. A write to it changes no entry, and a read of it returns 0.
- R10: Only one access happens per strobe assertion. Rewriting the word while the strobe is still set and acknowledged does not start a second access.
- R11: The read-data field keeps the value of the last read, including across later write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write enable |
| reg_rd | input | 1 | Host read enable |
| reg_addr | input | HOST_AW (12) | Host byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data; zero unless reading the access offset |

## Verification
The handshake is tried with writes and reads to several indices:
- Reads of the reset values tell the per-entry reset constants apart from a zeroed bank.
- A write followed by a read-back tells the write and read paths apart.
- An index of 0x20 catches a bank that wraps the index onto entry 0.

Holding the strobe across an acknowledge, rewriting the data while it is still held, and setting both strobes at once tell a true four-phase handshake apart from one that retriggers or accepts conflicting requests. Accesses at a foreign offset check that the decode is exact.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;

    // Field layout of the command/status word (software depends on it)
    localparam int WORD_W      = 32;
    localparam int IDX_W       = 8;
    localparam int DW          = 8;
    localparam int F_IDX_LSB   = 0;
    localparam int F_WDAT_LSB  = 8;
    localparam int F_RDAT_LSB  = 16;
    localparam int B_WR        = 24;
    localparam int B_RD        = 25;
    localparam int B_ACK       = 26;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DONE
    } acc_state_e;

    // Initial delay setting of each bank entry
    function automatic logic [7:0] dly_reset_value(input int idx);
        case (idx)
            0, 1:    return 8'd4;
            6:       return 8'd9;
            7:       return 8'd2;
            8:       return 8'd3;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/phy_acc_fsm.sv
module phy_acc_fsm
    import phy_acc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb_i,
    input  logic rd_stb_i,
    input  logic phy_ack_i,
    output logic phy_req_o,
    output logic phy_we_o,
    output logic ack_o,
    output logic cap_rd_o
);

    acc_state_e state_q, state_d;
    logic       we_q;
    logic       single_stb;
    logic       any_stb;

    assign single_stb = wr_stb_i ^ rd_stb_i;
    assign any_stb    = wr_stb_i | rd_stb_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (single_stb) state_d = ST_ISSUE;
            ST_ISSUE: if (phy_ack_i)  state_d = ST_DONE;
            ST_DONE:  if (!any_stb)   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register (direction latched as the access is accepted)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && single_stb) we_q <= wr_stb_i;
        end
    end

    // Outputs
    always_comb begin
        phy_req_o = 1'b0;
        phy_we_o  = 1'b0;
        ack_o     = 1'b0;
        cap_rd_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                phy_req_o = 1'b1;
                phy_we_o  = we_q;
                cap_rd_o  = phy_ack_i && !we_q;
            end
            ST_DONE:  ack_o = 1'b1;
            default:  ;
        endcase
    end

    // R4: request is held until the bank answers
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req_o && !phy_ack_i) |=> phy_req_o);

    // R6: acknowledge holds while a strobe stays set
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && any_stb) |=> ack_o);

    // R7: both strobes from idle never start a request
    a_r7_both_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_req_o && !ack_o && wr_stb_i && rd_stb_i) |=> !phy_req_o);

    // R10: no new request while acknowledged
    a_r10_no_req_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !phy_req_o);

endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
    import phy_acc_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             ack_o,
    output logic [DW-1:0]    rdata_o
);

    localparam int FLAT_W = N_ENTRIES * DW;

    logic [FLAT_W-1:0] flat;
    logic [DW-1:0]     sel;
    logic              start;

    assign start = req_i && !ack_o;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        localparam logic [IDX_W-1:0] G_IDX = IDX_W'(g);
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= DW'(dly_reset_value(g));
            else if (start && we_i && idx_i == G_IDX)
                q <= wdata_i;
        end
        assign flat[g*DW +: DW] = q;
    end

    // Out-of-range index selects nothing and reads zero
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_ENTRIES; i++)
            if (idx_i == IDX_W'(i)) sel = flat[i*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o <= start;
            if (start) rdata_o <= sel;
        end
    end

    // R5: a response always answers a request of the previous cycle
    a_r5_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(req_i));

endmodule

// File: rtl/phy_acc_port.sv
module phy_acc_port
    import phy_acc_pkg::*;
#(
    parameter int HOST_AW    = 12,
    parameter int CMD_OFFSET = 'h10,
    parameter int N_ENTRIES  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [HOST_AW-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata
);

    localparam logic [HOST_AW-1:0] OFF = HOST_AW'(CMD_OFFSET);

    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    wdat_q;
    logic [DW-1:0]    rdat_q;
    logic             wr_q, rd_q;
    logic             hit_wr;
    logic             phy_req, phy_we, phy_ack, ack, cap_rd;
    logic [DW-1:0]    bank_rdata;
    logic [WORD_W-1:0] word;
    logic             unused_host_bits;

    assign hit_wr = reg_wr && (reg_addr == OFF);
    assign unused_host_bits = ^{reg_wdata[31:B_ACK], reg_wdata[F_RDAT_LSB +: DW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            if (hit_wr) begin
                idx_q  <= reg_wdata[F_IDX_LSB +: IDX_W];
                wdat_q <= reg_wdata[F_WDAT_LSB +: DW];
                wr_q   <= reg_wdata[B_WR];
                rd_q   <= reg_wdata[B_RD];
            end
            if (cap_rd) rdat_q <= bank_rdata;
        end
    end

    assign word = {5'b0, ack, rd_q, wr_q, rdat_q, wdat_q, idx_q};
    assign reg_rdata = (reg_rd && reg_addr == OFF) ? word : '0;

    phy_acc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_q),
        .rd_stb_i  (rd_q),
        .phy_ack_i (phy_ack),
        .phy_req_o (phy_req),
        .phy_we_o  (phy_we),
        .ack_o     (ack),
        .cap_rd_o  (cap_rd)
    );

    phy_dly_bank #(.N_ENTRIES(N_ENTRIES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (phy_req),
        .we_i    (phy_we),
        .idx_i   (idx_q),
        .wdata_i (wdat_q),
        .ack_o   (phy_ack),
        .rdata_o (bank_rdata)
    );

    // R11: read-data field only moves on a read capture
    a_r11_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_rd) |=> $stable(rdat_q));

endmodule

// File: tb/tb_phy_acc_port.sv
module tb_phy_acc_port;

    localparam int OFF = 'h10;
    localparam int WD_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = 12'(OFF);
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       req;
        logic [31:0] mask;
        logic [31:0] exp;
    } sb_item_t;
    sb_item_t sb[$];

    always #10 clk = ~clk;

    phy_acc_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic record(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items as the design answers host reads
    always @(negedge clk) begin
        if (reg_rd && sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            record(it.req, reg_rdata & it.mask, it.exp & it.mask);
        end
    end

    task automatic host_write(int off, logic [31:0] data);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 12'(off); reg_wdata = data;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 12'(OFF);
    endtask

    // Driver: pushes the expected item, then issues the host read
    task automatic host_check(string req, int off, logic [31:0] mask, logic [31:0] exp);
        sb_item_t it;
        it.req = req; it.mask = mask; it.exp = exp;
        sb.push_back(it);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = 12'(off);
        @(negedge clk); #1;
        reg_rd = 1'b0; reg_addr = 12'(OFF);
    endtask

    task automatic wait_ack(string req);
        logic seen;
        seen = 1'b0;
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = 12'(OFF);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (reg_rdata[26]) begin seen = 1'b1; break; end
        end
        reg_rd = 1'b0;
        record(req, {31'b0, seen}, 32'd1);
    endtask

    function automatic logic [31:0] cmd(logic wr, logic rd, logic [7:0] val, logic [7:0] idx);
        return {6'b0, rd, wr, 8'h00, val, idx};
    endfunction

    task automatic phy_write(string req, logic [7:0] idx, logic [7:0] val);
        host_write(OFF, cmd(1'b0, 1'b0, val, idx));
        host_write(OFF, cmd(1'b1, 1'b0, val, idx));
        wait_ack(req);
        host_write(OFF, cmd(1'b0, 1'b0, val, idx));
        repeat (2) @(posedge clk);
    endtask

    task automatic phy_read(string req, logic [7:0] idx, logic [7:0] exp);
        host_write(OFF, cmd(1'b0, 1'b1, 8'h00, idx));
        wait_ack(req);
        host_check(req, OFF, 32'h00FF_0000, {8'h0, exp, 16'h0});
        host_write(OFF, cmd(1'b0, 1'b0, 8'h00, idx));
        repeat (2) @(posedge clk);
    endtask

    initial begin : watchdog
        #(WD_CYCLES * 20);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of the word
        host_check("R1", OFF, 32'hFFFF_FFFF, 32'h0);

        // R3: reset contents of the bank
        phy_read("R3", 8'h00, 8'd4);
        phy_read("R3", 8'h01, 8'd4);
        phy_read("R3", 8'h02, 8'd0);
        phy_read("R3", 8'h06, 8'd9);
        phy_read("R3", 8'h07, 8'd2);
        phy_read("R3", 8'h08, 8'd3);
        phy_read("R3", 8'h0F, 8'd0);

        // R2: fields read back, no access started with strobes clear
        host_write(OFF, cmd(1'b0, 1'b0, 8'hA5, 8'h3C));
        repeat (5) @(posedge clk);
        host_check("R2", OFF, 32'h0700_FFFF, 32'h0000_A53C);

        // R4 / R5: write then read back
        phy_write("R4", 8'h03, 8'h5A);
        phy_read("R5", 8'h03, 8'h5A);
        phy_write("R4", 8'h0F, 8'hC3);
        phy_read("R5", 8'h0F, 8'hC3);

        // R6: ack held with strobe set, then cleared
        host_write(OFF, cmd(1'b1, 1'b0, 8'h77, 8'h04));
        wait_ack("R6");
        repeat (5) @(posedge clk);
        host_check("R6", OFF, 32'h0400_0000, 32'h0400_0000);
        host_write(OFF, cmd(1'b0, 1'b0, 8'h77, 8'h04));
        host_check("R6", OFF, 32'h0400_0000, 32'h0);
        phy_read("R4", 8'h04, 8'h77);

        // R10: rewrite while acknowledged does not re-access
        host_write(OFF, cmd(1'b1, 1'b0, 8'h11, 8'h02));
        wait_ack("R10");
        host_write(OFF, cmd(1'b1, 1'b0, 8'h22, 8'h02));
        repeat (6) @(posedge clk);
        host_write(OFF, cmd(1'b0, 1'b0, 8'h22, 8'h02));
        repeat (2) @(posedge clk);
        phy_read("R10", 8'h02, 8'h11);

        // R7: both strobes refused, entry untouched
        host_write(OFF, cmd(1'b1, 1'b1, 8'hEE, 8'h06));
        repeat (8) @(posedge clk);
        host_check("R7", OFF, 32'h0400_0000, 32'h0);
        host_write(OFF, cmd(1'b0, 1'b0, 8'h00, 8'h06));
        repeat (2) @(posedge clk);
        phy_read("R7", 8'h06, 8'd9);

        // R11: read field survives a later write
        phy_write("R11", 8'h05, 8'h3D);
        host_check("R11", OFF, 32'h00FF_0000, 32'h0009_0000);

        // R8: foreign offset
        host_write(OFF, cmd(1'b0, 1'b0, 8'h12, 8'h34));
        host_write('h14, cmd(1'b1, 1'b0, 8'h99, 8'h01));
        repeat (6) @(posedge clk);
        host_check("R8", OFF, 32'h0700_FFFF, 32'h0000_1234);
        host_check("R8", 'h14, 32'hFFFF_FFFF, 32'h0);
        phy_read("R8", 8'h01, 8'd4);

        // R9: out-of-range index acked, no aliasing onto entry 0
        phy_write("R9", 8'h20, 8'h55);
        phy_read("R9", 8'h20, 8'h00);
        phy_read("R9", 8'h00, 8'd4);

        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule